// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from twelve sources and presents a single
request level to a processor. Each source owns an 8-bit control register that
holds an enable, a three-bit priority level and a pending flag. Ten sources are
driven by hardware inputs, which are synchronised and latched as pending on a
rising edge. Two sources have no hardware input and are raised by a software write.
Source 2 is a push-button style switch. Its register also shows the live
(synchronised) state of the switch.

The outgoing level is the highest priority among the sources that are both pending
and enabled. A bit in a general-control register gates that level as a whole. When
the processor runs an acknowledge cycle for a level, the block returns a vector. The
vector is a programmable 8-bit base plus the index of the winning source at that
level. Software clears the pending flag afterwards. The acknowledge is a
valid/ready request, and the vector comes back on a valid/ready response channel.

Source indices are fixed: 0 power-fail, 1 bus error, 2 abort switch, 3 serial,
4 ethernet, 5 SCSI, 6 DMA, 7 printer, 8 timer 1, 9 timer 2, 10 software 1,
11 software 2. The register addresses are 0..11 for the source registers, 12 for
general control and 13 for the vector base. A write takes effect at the clock edge
on which `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `irq_hub`

## Requirements
- R1: After reset every register reads 0 (the switch state bit reads the input), `irq_level` is 0, `vec_valid` is 0 and `ack_ready` is 1.
- R2: Source register layout: bit 3 is the enable and bits 2:0 are the level. Both read back as written. Bits 5:4 always read 0, and on hardware sources bit 6 reads 0 and a write to it is ignored.
- R3: Bit 7 reads the pending flag. Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves it unchanged.
- R4: A hardware input passes through two synchronising flops. Its rising edge sets pending on the third clock edge after the input changes. A level that stays high does not set pending again after it has been cleared.
- R5: Sources 10 and 11 are set pending by writing 1 to bit 6 of their register. Their hardware input bits are ignored.
- R6: Bit 6 of the source 2 register reads the synchronised live state of input 2, whether or not that source is enabled.
- R7: `irq_level` is the largest level among sources that are pending, enabled and have a non-zero level. It is 0 when there is no such source.
- R8: When several sources share the acknowledged level, the lowest index wins the vector.
- R9: Bit 4 of the general-control register (address 12) is a global enable. While it is 0, `irq_level` is 0. Only that bit reads back.
- R10: An accepted acknowledge for level L returns the base (address 13) plus the winning index at L, or the base plus 12 if no pending, enabled source has level L. The sum wraps modulo 256. The acknowledge does not clear the pending flag.
- R11: `ack_ready` equals `!vec_valid`. Once `vec_valid` rises, the vector stays valid and unchanged until a cycle with `vec_ready` high. An acknowledge offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 12 | Hardware request inputs, one per source index |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data |
| irq_level | output | 3 | Request level to the processor, 0 means none |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge request can be accepted |
| ack_lvl | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector response valid |
| vec_ready | input | 1 | Vector response consumed |
| vec_data | output | 8 | Vector number |

## Verification
The bench builds the block with its default parameters: twelve sources, three-bit levels, an 8-bit vector, the switch at index 2 and software sources at 10 and 11. With these values every slot kind is reachable: a hardware edge, a software set, and the live switch bit. A base of 0xFA makes the vector sum wrap past 255, both for a real winner and for the spurious value of base plus 12. Two sources placed at the same level show the tie rule, and a response held without `vec_ready` shows the back-pressure behaviour.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_W  = 8;
  localparam int B_PEND = 7;
  localparam int B_AUX  = 6;
  localparam int B_GIE  = 4;
  localparam int B_EN   = 3;

  typedef enum logic [1:0] {
    SRC_HW     = 2'd0,
    SRC_SOFT   = 2'd1,
    SRC_SWITCH = 2'd2
  } src_kind_e;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_hub_pkg::*;
#(
  parameter src_kind_e KIND  = SRC_HW,
  parameter int        LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_in,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             pend,
  output logic             en,
  output logic [LVL_W-1:0] lvl
);
  localparam logic IS_HW   = (KIND != SRC_SOFT);
  localparam logic IS_SOFT = (KIND == SRC_SOFT);
  localparam logic IS_SW   = (KIND == SRC_SWITCH);

  // [0],[1] synchroniser, [2] previous synchronised value
  logic [2:0] sync_q;
  logic       rise, set_now, clr_now;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], hw_in};
  end

  assign rise    = sync_q[1] & ~sync_q[2] & IS_HW;
  assign set_now = rise | (wr_sel & wr_data[B_AUX] & IS_SOFT);
  assign clr_now = wr_sel & wr_data[B_PEND];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
      lvl  <= '0;
    end else begin
      pend <= set_now | (pend & ~clr_now);
      if (wr_sel) begin
        en  <= wr_data[B_EN];
        lvl <= wr_data[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[B_PEND]      = pend;
    rd_data[B_AUX]       = IS_SW & sync_q[1];
    rd_data[B_EN]        = en;
    rd_data[LVL_W-1:0]   = lvl;
  end

  // R3: a clear with no concurrent set leaves the flag low
  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_data[B_PEND] && !set_now) |=> !pend);
  // R4: pending only goes away through a clear write
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wr_sel) |=> pend);
  // R4: a synchronised rising edge on a hardware slot latches pending
  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise) |=> pend);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC  = 12,
  parameter int LVL_W = 3,
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             act,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
  input  logic                        gie,
  input  logic [LVL_W-1:0]            ack_lvl,
  output logic [LVL_W-1:0]            top_lvl,
  output logic                        hit_found,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [LVL_W-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && lvl[i] > best) best = lvl[i];
    end
  end

  assign top_lvl = gie ? best : '0;

  // descending scan so the lowest matching index is left last
  always_comb begin
    hit_found = 1'b0;
    hit_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i] && lvl[i] == ack_lvl) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
    end
  end

  // R7: a non-zero output level is backed by an active source
  p_lvl_backed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_lvl != '0) |-> (act != '0));
  // R8: the chosen source really is active at the asked level
  p_hit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_found |-> (act[hit_idx] && lvl[hit_idx] == ack_lvl));
endmodule

// File: rtl/irq_vec_resp.sv
module irq_vec_resp #(
  parameter int NSRC  = 12,
  parameter int VEC_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  output logic             ack_ready,
  input  logic             hit_found,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [VEC_W-1:0] base,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_data
);
  logic             accept;
  logic [VEC_W-1:0] offs;

  assign ack_ready = ~vec_valid;
  assign accept    = ack_valid & ack_ready;
  assign offs      = hit_found ? VEC_W'(hit_idx) : VEC_W'(NSRC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else if (accept) begin
      vec_valid <= 1'b1;
      vec_data  <= base + offs;
    end else if (vec_valid && vec_ready) begin
      vec_valid <= 1'b0;
    end
  end

  // R11: a stalled response keeps its vector
  p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));
  // R11: a consumed response drops valid
  p_vec_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !vec_valid);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int              NSRC      = 12,
  parameter int              LVL_W     = 3,
  parameter int              VEC_W     = 8,
  parameter int              SW_IDX    = 2,
  parameter logic [NSRC-1:0] SOFT_MASK = 12'hC00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [LVL_W-1:0] irq_level,
  input  logic             ack_valid,
  output logic             ack_ready,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_data
);
  localparam int IDX_W   = $clog2(NSRC + 1);
  localparam int GC_ADDR = NSRC;
  localparam int VB_ADDR = NSRC + 1;

  logic [NSRC-1:0]             slot_pend, slot_en, slot_act;
  logic [NSRC-1:0][LVL_W-1:0]  slot_lvl;
  logic [NSRC-1:0][REG_W-1:0]  slot_rd;
  logic                        gie_q;
  logic [VEC_W-1:0]            base_q;
  logic                        hit_found;
  logic [IDX_W-1:0]            hit_idx;

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    localparam src_kind_e K = (i == SW_IDX) ? SRC_SWITCH :
                              (SOFT_MASK[i] ? SRC_SOFT : SRC_HW);
    irq_src_slot #(.KIND(K), .LVL_W(LVL_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_in   (src_in[i]),
      .wr_sel  (wr_en && wr_addr == 4'(i)),
      .wr_data (wr_data),
      .rd_data (slot_rd[i]),
      .pend    (slot_pend[i]),
      .en      (slot_en[i]),
      .lvl     (slot_lvl[i])
    );
    assign slot_act[i] = slot_pend[i] & slot_en[i] & (slot_lvl[i] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      base_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 4'(GC_ADDR)) gie_q  <= wr_data[B_GIE];
      if (wr_addr == 4'(VB_ADDR)) base_q <= wr_data[VEC_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < 4'(NSRC))             rd_data = slot_rd[rd_addr];
    else if (rd_addr == 4'(GC_ADDR))    rd_data[B_GIE] = gie_q;
    else if (rd_addr == 4'(VB_ADDR))    rd_data = 8'(base_q);
  end

  irq_prio_sel #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (slot_act),
    .lvl       (slot_lvl),
    .gie       (gie_q),
    .ack_lvl   (ack_lvl),
    .top_lvl   (irq_level),
    .hit_found (hit_found),
    .hit_idx   (hit_idx)
  );

  irq_vec_resp #(.NSRC(NSRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ack_ready (ack_ready),
    .hit_found (hit_found),
    .hit_idx   (hit_idx),
    .base      (base_q),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .vec_data  (vec_data)
  );

  // R9: with the global enable off no level reaches the processor
  p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> (irq_level == '0));
  // R11: the request side is ready exactly when no response is held
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ready == !vec_valid);
endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] src_in;
  logic        wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [2:0]  irq_level, ack_lvl;
  logic        ack_valid, ack_ready, vec_valid, vec_ready;
  logic [7:0]  vec_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  irq_hub dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_level(irq_level), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .ack_lvl(ack_lvl), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(string req, logic [2:0] l, logic [7:0] exp);
    @(negedge clk);
    ack_valid = 1'b1; ack_lvl = l;
    @(negedge clk);
    ack_valid = 1'b0;
    chk({req, " valid"}, vec_valid, 1);
    chk({req, " vector"}, vec_data, exp);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    chk({req, " drop"}, vec_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 level", irq_level, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 ack_ready", ack_ready, 1);
    for (int a = 0; a < 14; a++) rd_chk("R1 reg", 4'(a), 8'h00);
  endtask

  task automatic t_regs;
    wr(4'd3, 8'h3D);
    rd_chk("R2 layout", 4'd3, 8'h0D);
    wr(4'd3, 8'h00);
    rd_chk("R2 zero", 4'd3, 8'h00);
  endtask

  task automatic t_hw_edge;
    wr(4'd12, 8'h10);
    wr(4'd4, 8'h0B);
    @(negedge clk); src_in[4] = 1'b1;
    cyc(2);
    rd_chk("R4 not yet", 4'd4, 8'h0B);
    cyc(1);
    rd_chk("R4 third edge", 4'd4, 8'h8B);
    chk("R7 level 3", irq_level, 3);
    wr(4'd4, 8'h0B);
    rd_chk("R3 write 0 keeps", 4'd4, 8'h8B);
    wr(4'd4, 8'h8B);
    cyc(4);
    rd_chk("R4 no re-set on held high", 4'd4, 8'h0B);
    chk("R3 level after clear", irq_level, 0);
    src_in[4] = 1'b0;
    wr(4'd4, 8'h00);
  endtask

  task automatic t_soft;
    wr(4'd10, 8'h4C);
    rd_chk("R5 soft set", 4'd10, 8'h8C);
    chk("R5 level", irq_level, 4);
    @(negedge clk); src_in[11] = 1'b1;
    cyc(4); src_in[11] = 1'b0;
    rd_chk("R5 hw input ignored", 4'd11, 8'h00);
    wr(4'd10, 8'h8C);
    rd_chk("R3 soft clear", 4'd10, 8'h0C);
    chk("R5 level cleared", irq_level, 0);
    wr(4'd10, 8'h00);
  endtask

  task automatic t_switch;
    @(negedge clk); src_in[2] = 1'b1;
    cyc(3);
    rd_chk("R6 switch high", 4'd2, 8'hC0);
    chk("R6 disabled no level", irq_level, 0);
    src_in[2] = 1'b0;
    cyc(3);
    rd_chk("R6 switch low", 4'd2, 8'h80);
    wr(4'd2, 8'h80);
    rd_chk("R6 cleared", 4'd2, 8'h00);
  endtask

  task automatic t_priority;
    wr(4'd10, 8'h4A);
    wr(4'd11, 8'h4E);
    chk("R7 max of 2 and 6", irq_level, 6);
    wr(4'd11, 8'h06);
    chk("R7 disabled excluded", irq_level, 2);
    wr(4'd11, 8'h08);
    chk("R7 level zero excluded", irq_level, 2);
    wr(4'd10, 8'h80);
    wr(4'd11, 8'h80);
    chk("R7 none", irq_level, 0);
  endtask

  task automatic t_gie;
    wr(4'd10, 8'h4D);
    chk("R9 on", irq_level, 5);
    wr(4'd12, 8'h00);
    chk("R9 off", irq_level, 0);
    rd_chk("R9 readback 0", 4'd12, 8'h00);
    wr(4'd12, 8'hFF);
    rd_chk("R9 only bit 4", 4'd12, 8'h10);
    chk("R9 on again", irq_level, 5);
    wr(4'd10, 8'h80);
  endtask

  task automatic t_ack;
    wr(4'd13, 8'hFA);
    rd_chk("R10 base readback", 4'd13, 8'hFA);
    wr(4'd1, 8'h0D);
    @(negedge clk); src_in[1] = 1'b1;
    cyc(4); src_in[1] = 1'b0;
    wr(4'd10, 8'h4D);
    chk("R8 level", irq_level, 5);
    @(negedge clk);
    ack_valid = 1'b1; ack_lvl = 3'd5;
    @(negedge clk);
    ack_lvl = 3'd3;
    chk("R11 valid", vec_valid, 1);
    chk("R8 tie lowest index", vec_data, 8'hFB);
    chk("R11 not ready", ack_ready, 0);
    cyc(2);
    ack_valid = 1'b0;
    chk("R11 held valid", vec_valid, 1);
    chk("R11 busy ack ignored", vec_data, 8'hFB);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    chk("R11 dropped", vec_valid, 0);
    rd_chk("R10 pending kept", 4'd1, 8'h8D);
    wr(4'd1, 8'h80);
    ack("R10 wrap", 3'd5, 8'h04);
    ack("R10 spurious", 3'd3, 8'h06);
    wr(4'd10, 8'h80);
  endtask

  initial begin
    rst_n = 1'b0; src_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; ack_valid = 1'b0; ack_lvl = '0; vec_ready = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_hw_edge();
    t_soft();
    t_switch();
    t_priority();
    t_gie();
    t_ack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule